// File: doc/BRIEF.md
# Control-Word Register File with I2C Block-Command Access

This block is an I2C target that holds a small byte-addressed file of 4-bit control words, packed two per byte, plus a few fixed identification bytes. A controller reaches it with framed block commands. A write frame carries a command byte, a byte count, a reserved byte, a device/function byte, a register index split into high and low bytes, and then one, two or four data bytes. The access size comes from two bits of the command byte.

A read takes two steps. First a full command frame with the read size code sets the target block. Then the controller sends only the command byte, issues a repeated start with the read bit set, and clocks out six bytes: a response count, a status byte and four data bytes. The data always comes from a 4-byte-aligned block and is sent starting with the highest-indexed byte. A short read with no full command frame before it reports the outcome of the last complete frame. This lets software confirm a write and see the block it touched.

The bit layer is an oversampled front end. It synchronises SCL and SDA to the system clock and pulls SDA low through an open-drain enable.

Top module: `rcw_i2c_target`

## Requirements
- R1: After reset, SDA is released. The status is success (0x01) and the read block is index 0, so a short read returns 0x05, 0x01, then identification bytes 3, 2, 1, 0.
- R2: Only the 7-bit address TGT_ADDR (default 0x58) is acknowledged. Any other address gets no acknowledge, and its frame changes no state.
- R3: The command byte has bit 7 = begin, bit 6 = end and bit 1 = block, and bits 3:2 give the size. Command 0xC6 with count 5 writes one data byte to the exact index given by the low index byte.
- R4: Command 0xCA with count 6 is a 16-bit write. An odd index is rounded down to even. The first data byte goes to index+1 and the second to index.
- R5: Command 0xCE with count 8 is a 32-bit write. The two lowest index bits are ignored. The four data bytes land at base+3, base+2, base+1 and base, in order of arrival.
- R6: Command 0xC2 with count 4 selects a read block, which is the index with its two low bits cleared. The next repeated-start read returns 0x05, the status, then bytes base+3 down to base. Any byte read past the sixth is 0xFF.
- R7: A write is ignored as a whole if it touches indexes 0–7 or 31, or runs past index 30, or has a non-zero high index byte. Its status is 0x10 (abort), and a short read then returns four 0x00 data bytes.
- R8: A frame whose begin, end or block bit is clear, or whose count differs from 4 plus the data size, aborts with status 0x10 and writes nothing.
- R9: A frame that ends before its count is reached leaves the status, the read block and the storage unchanged. Bytes after the counted ones are ignored.
- R10: The target changes SDA only while SCL is low. It releases SDA at a stop, and after a controller NACK it stays released until the next start.
- R11: Indexes 0–4 read the ID_VALUE parameter (byte i = bits 8i+7:8i). Indexes 5–7 and 31 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | When high, the target pulls SDA low |

## Verification
The hardest case to reach is a read after the command phase. The bench must send a frame containing only the command byte, then turn the bus around with a repeated start, without the target committing or losing the prior frame's index and status. The bench's controller tasks build exactly this sequence after every write and after every rejected frame. The status and the zeroed data then show at the pins. A read that runs past six bytes and ends in a NACK followed by one more probe clock checks that the target returns to a released line.

// File: rtl/rcw_pkg.sv
package rcw_pkg;
  localparam int REG_BYTES = 32;
  localparam int IDX_W     = $clog2(REG_BYTES);
  localparam int ID_LEN    = 5;
  localparam int WR_LO     = 8;
  localparam int WR_HI     = 30;
  localparam int I2C_AW    = 7;
  localparam int RIDX_W    = 4;

  localparam logic [7:0] ST_OK    = 8'h01;
  localparam logic [7:0] ST_ABORT = 8'h10;
  localparam logic [7:0] RSP_CNT  = 8'h05;

  typedef enum logic [1:0] {
    SZ_RD32 = 2'b00,
    SZ_WR8  = 2'b01,
    SZ_WR16 = 2'b10,
    SZ_WR32 = 2'b11
  } acc_sz_e;

  typedef enum logic [2:0] {
    P_IDLE, P_ADDR, P_WR, P_RD, P_SKIP
  } phy_st_e;
endpackage

// File: rtl/rcw_i2c_phy.sv
module rcw_i2c_phy
  import rcw_pkg::*;
#(
  parameter logic [I2C_AW-1:0] TGT_ADDR = 7'h58
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       start_o,
  output logic       stop_o,
  output logic       rx_vld_o,
  output logic [7:0] rx_byte_o,
  input  logic [7:0] tx_byte_i,
  output logic       tx_adv_o
);
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q, scl_s, sda_s, rise, fall;
  phy_st_e    st_q;
  logic [3:0] cnt_q;
  logic       in_ack_q, drv_q, nack_q;
  logic [7:0] sh_q;
  logic [6:0] tx_sh_q;

  assign scl_s   = scl_sy[1];
  assign sda_s   = sda_sy[1];
  assign start_o = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise    = scl_s & ~scl_q;
  assign fall    = ~scl_s & scl_q;
  assign sda_oe_o = drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= P_IDLE;
      cnt_q     <= '0;
      in_ack_q  <= 1'b0;
      drv_q     <= 1'b0;
      nack_q    <= 1'b0;
      sh_q      <= '0;
      tx_sh_q   <= '0;
      rx_vld_o  <= 1'b0;
      rx_byte_o <= '0;
      tx_adv_o  <= 1'b0;
    end else begin
      rx_vld_o <= 1'b0;
      tx_adv_o <= 1'b0;
      if (start_o) begin
        st_q     <= P_ADDR;
        cnt_q    <= '0;
        in_ack_q <= 1'b0;
        drv_q    <= 1'b0;
      end else if (stop_o) begin
        st_q     <= P_IDLE;
        cnt_q    <= '0;
        in_ack_q <= 1'b0;
        drv_q    <= 1'b0;
      end else if (st_q != P_IDLE && st_q != P_SKIP) begin
        if (rise) begin
          if (cnt_q < 4'd8) begin
            cnt_q <= cnt_q + 4'd1;
            sh_q  <= {sh_q[6:0], sda_s};
          end else if (in_ack_q) begin
            nack_q <= sda_s;
          end
        end else if (fall) begin
          if (cnt_q < 4'd8) begin
            if (st_q == P_RD && cnt_q != 4'd0) begin
              drv_q   <= ~tx_sh_q[6];
              tx_sh_q <= {tx_sh_q[5:0], 1'b0};
            end
          end else if (!in_ack_q) begin
            in_ack_q <= 1'b1;
            unique case (st_q)
              P_ADDR: if (sh_q[7:1] == TGT_ADDR) drv_q <= 1'b1;
                      else st_q <= P_SKIP;
              P_WR: begin
                drv_q     <= 1'b1;
                rx_vld_o  <= 1'b1;
                rx_byte_o <= sh_q;
              end
              default: drv_q <= 1'b0;
            endcase
          end else begin
            in_ack_q <= 1'b0;
            cnt_q    <= '0;
            // end of ack slot: turn around or load next byte
            if ((st_q == P_ADDR && sh_q[0]) || (st_q == P_RD && !nack_q)) begin
              st_q     <= P_RD;
              tx_sh_q  <= tx_byte_i[6:0];
              drv_q    <= ~tx_byte_i[7];
              tx_adv_o <= 1'b1;
            end else begin
              drv_q <= 1'b0;
              if (st_q == P_ADDR) st_q <= P_WR;
              else if (st_q == P_RD) st_q <= P_SKIP;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/rcw_cmd_engine.sv
module rcw_cmd_engine
  import rcw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rx_vld_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             tx_adv_i,
  input  logic [31:0]      rd_word_i,
  output logic [7:0]       tx_byte_o,
  output logic             we_o,
  output logic [IDX_W-1:0] wr_base_o,
  output logic [2:0]       wr_nb_o,
  output logic [31:0]      wr_data_o,
  output logic [IDX_W-1:0] rd_base_o
);
  logic [RIDX_W-1:0] rx_idx_q;
  logic [2:0]  rd_idx_q;
  logic [2:0]  frm_q;      // begin, end, block
  acc_sz_e     sz_q;
  logic [7:0]  cnt_q, regh_q, regl_q, status_q;
  logic [31:0] wdata_q;
  logic        done_q, rd_ok_q;
  logic [7:0]  base, exp_cnt;
  logic [8:0]  last;
  logic        is_rd, frame_ok, acc_ok;

  always_comb begin
    unique case (sz_q)
      SZ_WR8:  begin wr_nb_o = 3'd1; base = regl_q; end
      SZ_WR16: begin wr_nb_o = 3'd2; base = {regl_q[7:1], 1'b0}; end
      default: begin wr_nb_o = 3'd4; base = {regl_q[7:2], 2'b00}; end
    endcase
    is_rd    = (sz_q == SZ_RD32);
    exp_cnt  = is_rd ? 8'd4 : 8'd4 + {5'd0, wr_nb_o};
    last     = {1'b0, base} + {6'd0, wr_nb_o} - 9'd1;
    frame_ok = (&frm_q) && (cnt_q == exp_cnt) && (regh_q == 8'd0);
    acc_ok   = frame_ok && (is_rd ? (int'(base) < REG_BYTES)
                                  : (int'(base) >= WR_LO && int'(last) <= WR_HI));
  end

  assign we_o      = done_q && acc_ok && !is_rd;
  assign wr_base_o = base[IDX_W-1:0];
  assign wr_data_o = wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_idx_q  <= '0;
      rd_idx_q  <= '0;
      frm_q     <= '0;
      sz_q      <= SZ_RD32;
      cnt_q     <= '0;
      regh_q    <= '0;
      regl_q    <= '0;
      wdata_q   <= '0;
      done_q    <= 1'b0;
      status_q  <= ST_OK;
      rd_ok_q   <= 1'b1;
      rd_base_o <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rx_idx_q <= '0;
        rd_idx_q <= '0;
      end else begin
        if (tx_adv_i && rd_idx_q != 3'd7) rd_idx_q <= rd_idx_q + 3'd1;
        if (rx_vld_i) begin
          unique case (rx_idx_q)
            4'd0: begin
              frm_q <= {rx_byte_i[7], rx_byte_i[6], rx_byte_i[1]};
              sz_q  <= acc_sz_e'(rx_byte_i[3:2]);
            end
            4'd1: cnt_q  <= rx_byte_i;
            4'd4: regh_q <= rx_byte_i;
            4'd5: regl_q <= rx_byte_i;
            4'd2, 4'd3: ;
            default: wdata_q <= {wdata_q[23:0], rx_byte_i};
          endcase
          if (rx_idx_q != '1) rx_idx_q <= rx_idx_q + 1'b1;
          done_q <= (rx_idx_q >= 4'd5) &&
                    ({5'd0, rx_idx_q} == {1'b0, cnt_q} + 9'd1);
        end
      end
      if (done_q) begin
        status_q  <= acc_ok ? ST_OK : ST_ABORT;
        rd_ok_q   <= acc_ok;
        rd_base_o <= {base[IDX_W-1:2], 2'b00};
      end
    end
  end

  always_comb begin
    unique case (rd_idx_q)
      3'd0:    tx_byte_o = RSP_CNT;
      3'd1:    tx_byte_o = status_q;
      3'd2:    tx_byte_o = rd_ok_q ? rd_word_i[31:24] : 8'h00;
      3'd3:    tx_byte_o = rd_ok_q ? rd_word_i[23:16] : 8'h00;
      3'd4:    tx_byte_o = rd_ok_q ? rd_word_i[15:8]  : 8'h00;
      3'd5:    tx_byte_o = rd_ok_q ? rd_word_i[7:0]   : 8'h00;
      default: tx_byte_o = 8'hFF;
    endcase
  end
endmodule

// File: rtl/rcw_regfile.sv
module rcw_regfile
  import rcw_pkg::*;
#(
  parameter logic [8*ID_LEN-1:0] ID_VALUE = 40'h04_86_80_B3_2C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_base_i,
  input  logic [2:0]       wr_nb_i,
  input  logic [31:0]      wr_data_i,
  input  logic [IDX_W-1:0] rd_base_i,
  output logic [31:0]      rd_word_o
);
  logic [8*REG_BYTES-1:0] bytes_flat;

  for (genvar i = 0; i < REG_BYTES; i++) begin : g_byte
    if (i < ID_LEN) begin : g_id
      assign bytes_flat[8*i +: 8] = ID_VALUE[8*i +: 8];
    end else if (i >= WR_LO && i <= WR_HI) begin : g_rw
      logic [7:0]     cell_q;
      logic [IDX_W:0] rel;
      logic           hit;
      assign rel = (IDX_W+1)'(i) - {1'b0, wr_base_i};
      assign hit = we_i && !rel[IDX_W] && (rel < (IDX_W+1)'(wr_nb_i));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  cell_q <= '0;
        else if (hit) cell_q <= wr_data_i[8*rel[1:0] +: 8];
      end
      assign bytes_flat[8*i +: 8] = cell_q;
    end else begin : g_rsv
      assign bytes_flat[8*i +: 8] = 8'h00;
    end
  end

  assign rd_word_o = bytes_flat[8*rd_base_i +: 32];
endmodule

// File: rtl/rcw_i2c_target.sv
module rcw_i2c_target
  import rcw_pkg::*;
#(
  parameter logic [I2C_AW-1:0]   TGT_ADDR = 7'h58,
  parameter logic [8*ID_LEN-1:0] ID_VALUE = 40'h04_86_80_B3_2C
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  logic             start, stop, rx_vld, tx_adv, we;
  logic [7:0]       rx_byte, tx_byte;
  logic [IDX_W-1:0] wr_base, rd_base;
  logic [2:0]       wr_nb;
  logic [31:0]      wr_data, rd_word;

  rcw_i2c_phy #(.TGT_ADDR(TGT_ADDR)) u_phy (
    .clk_i, .rst_ni, .scl_i, .sda_i, .sda_oe_o,
    .start_o(start), .stop_o(stop), .rx_vld_o(rx_vld), .rx_byte_o(rx_byte),
    .tx_byte_i(tx_byte), .tx_adv_o(tx_adv)
  );

  rcw_cmd_engine u_eng (
    .clk_i, .rst_ni, .start_i(start), .rx_vld_i(rx_vld), .rx_byte_i(rx_byte),
    .tx_adv_i(tx_adv), .rd_word_i(rd_word), .tx_byte_o(tx_byte), .we_o(we),
    .wr_base_o(wr_base), .wr_nb_o(wr_nb), .wr_data_o(wr_data), .rd_base_o(rd_base)
  );

  rcw_regfile #(.ID_VALUE(ID_VALUE)) u_rf (
    .clk_i, .rst_ni, .we_i(we), .wr_base_i(wr_base), .wr_nb_i(wr_nb),
    .wr_data_i(wr_data), .rd_base_i(rd_base), .rd_word_o(rd_word)
  );
endmodule

// File: rtl/rcw_i2c_target_chk.sv
module rcw_i2c_target_chk
  import rcw_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   sda_oe_i,
  input logic                   scl_s_i,
  input logic                   start_i,
  input logic                   stop_i,
  input logic                   we_i,
  input logic [8*REG_BYTES-1:0] cells_i,
  input logic [7:0]             status_i,
  input logic [2:0]             rd_idx_i
);
  a_r10_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !scl_s_i);

  a_r10_release_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_i) |-> (!scl_s_i || $past(stop_i) || $past(start_i)));

  a_r10_release_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  a_r9_store_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cells_i));

  a_r7_status_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == ST_OK) || (status_i == ST_ABORT));

  a_r6_rd_idx_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (rd_idx_i == 3'd0));
endmodule

bind rcw_i2c_target rcw_i2c_target_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sda_oe_i (sda_oe_o),
  .scl_s_i  (u_phy.scl_s),
  .start_i  (start),
  .stop_i   (stop),
  .we_i     (we),
  .cells_i  (u_rf.bytes_flat),
  .status_i (u_eng.status_q),
  .rd_idx_i (u_eng.rd_idx_q)
);

// File: tb/rcw_i2c_target_tb_top.sv
module rcw_i2c_target_tb_top;
  localparam int          Q    = 8;
  localparam logic [6:0]  TGT  = 7'h58;
  localparam logic [39:0] IDV  = 40'h04_86_80_B3_2C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_r = 1'b1, sda_low = 1'b0, ctl_owns = 1'b0;
  logic sda_oe, sda_line;
  assign sda_line = ~(sda_low | sda_oe);

  rcw_i2c_target #(.TGT_ADDR(TGT), .ID_VALUE(IDV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_r), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  int n_chk = 0, n_fail = 0, viol = 0;
  bit done = 1'b0;
  byte unsigned mdl [32];
  byte unsigned m_status = 8'h01;
  bit  m_rdok = 1'b1;
  int  m_rdbase = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock bus model: controller-owned bit windows and SDA stable while SCL high (R10)
  logic oe_prev = 1'b0, scl_prev = 1'b1;
  always @(posedge clk) begin
    if (rst_n) begin
      if (ctl_owns && scl_r && sda_oe) viol++;
      if (sda_oe != oe_prev && scl_r && scl_prev) viol++;
    end
    oe_prev  <= sda_oe;
    scl_prev <= scl_r;
  end

  function automatic byte unsigned mval(int i);
    if (i < 5) return IDV[8*i +: 8];
    if (i < 8 || i > 30) return 8'h00;
    return mdl[i];
  endfunction

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_low = 1'b0; wq(Q);
    scl_r = 1'b1;   wq(2*Q);
    sda_low = 1'b1; wq(2*Q);
    scl_r = 1'b0;   wq(Q);
  endtask

  task automatic bus_stop();
    sda_low = 1'b1; wq(Q);
    scl_r = 1'b1;   wq(2*Q);
    sda_low = 1'b0; wq(2*Q);
  endtask

  task automatic put_bit(bit b);
    ctl_owns = 1'b1; sda_low = ~b; wq(Q);
    scl_r = 1'b1; wq(2*Q);
    scl_r = 1'b0; wq(Q);
    ctl_owns = 1'b0;
  endtask

  task automatic get_bit(output bit b);
    sda_low = 1'b0; wq(Q);
    scl_r = 1'b1;   wq(Q);
    b = sda_line;   wq(Q);
    scl_r = 1'b0;   wq(Q);
  endtask

  task automatic put_byte(byte unsigned v, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(s);
    ack = ~s;
  endtask

  task automatic get_byte(bit ack, output byte unsigned v);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~ack);
    sda_low = 1'b0;
  endtask

  task automatic mdl_frame(byte unsigned cmd, cnt, regh, regl,
                           byte unsigned d [4], int nd);
    int sz, nb, ex, base;
    bit ok;
    if (cnt < 4 || 4 + nd < cnt) return;
    sz   = cmd[3:2];
    nb   = (sz == 1) ? 1 : (sz == 2) ? 2 : 4;
    ex   = (sz == 0) ? 4 : 4 + nb;
    base = (sz == 1) ? regl : (sz == 2) ? (regl & 8'hFE) : (regl & 8'hFC);
    ok   = cmd[7] && cmd[6] && cmd[1] && cnt == ex && regh == 0;
    if (sz == 0) ok = ok && base < 32;
    else         ok = ok && base >= 8 && base + nb - 1 <= 30;
    m_status = ok ? 8'h01 : 8'h10;
    m_rdok   = ok;
    m_rdbase = base & 28;
    if (ok && sz != 0)
      for (int j = 0; j < nb; j++) mdl[base + j] = d[nb - 1 - j];
  endtask

  task automatic wr_frame(string req, byte unsigned cmd, cnt, regh, regl,
                          byte unsigned d0, d1, d2, d3, int nd);
    bit ack;
    byte unsigned d [4];
    d = '{d0, d1, d2, d3};
    bus_start();
    put_byte({TGT, 1'b0}, ack);
    chk(ack, req, ack, 1);
    put_byte(cmd, ack); put_byte(cnt, ack); put_byte(8'h00, ack);
    put_byte(8'h00, ack); put_byte(regh, ack); put_byte(regl, ack);
    for (int k = 0; k < nd; k++) put_byte(d[k], ack);
    bus_stop();
    mdl_frame(cmd, cnt, regh, regl, d, nd);
  endtask

  // command byte only, repeated start, read nb bytes, NACK the last
  task automatic rd_short(string req, int nb, bit probe);
    bit ack, b;
    byte unsigned v, e;
    bus_start();
    put_byte({TGT, 1'b0}, ack);
    put_byte(8'hC2, ack);
    bus_start();
    put_byte({TGT, 1'b1}, ack);
    chk(ack, req, ack, 1);
    for (int k = 0; k < nb; k++) begin
      get_byte(k != nb - 1, v);
      if (k == 0)      e = 8'h05;
      else if (k == 1) e = m_status;
      else if (k < 6)  e = m_rdok ? mval(m_rdbase + 5 - k) : 8'h00;
      else             e = 8'hFF;
      chk(v == e, req, v, e);
    end
    if (probe) begin
      get_bit(b);
      chk(b == 1'b1, "R10", b, 1);
    end
    bus_stop();
  endtask

  task automatic rd_full(string req, byte unsigned regl);
    wr_frame(req, 8'hC2, 8'd4, 8'd0, regl, 0, 0, 0, 0, 0);
    rd_short(req, 6, 1'b0);
  endtask

  initial begin
    bit ack;
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    rd_short("R1", 6, 1'b0);
    rd_full("R11", 8'h02);

    wr_frame("R3", 8'hC6, 8'd5, 8'd0, 8'd9, 8'h5A, 0, 0, 0, 1);
    rd_short("R3", 6, 1'b0);
    wr_frame("R4", 8'hCA, 8'd6, 8'd0, 8'd13, 8'h12, 8'h34, 0, 0, 2);
    rd_short("R4", 6, 1'b0);
    wr_frame("R5", 8'hCE, 8'd8, 8'd0, 8'h13, 8'h11, 8'h22, 8'h33, 8'h44, 4);
    rd_short("R5", 6, 1'b0);
    rd_full("R6", 8'h0E);

    wr_frame("R7", 8'hC6, 8'd5, 8'd0, 8'd3, 8'hEE, 0, 0, 0, 1);
    rd_short("R7", 6, 1'b0);
    rd_full("R11", 8'h00);
    wr_frame("R7", 8'hC6, 8'd5, 8'd0, 8'd31, 8'hEE, 0, 0, 0, 1);
    rd_short("R7", 6, 1'b0);
    wr_frame("R7", 8'hCE, 8'd8, 8'd0, 8'd28, 1, 2, 3, 4, 4);
    rd_short("R7", 6, 1'b0);
    wr_frame("R7", 8'hC6, 8'd5, 8'd1, 8'd9, 8'hEE, 0, 0, 0, 1);
    wr_frame("R7", 8'hCA, 8'd6, 8'd0, 8'd7, 8'hEE, 8'hEE, 0, 0, 2);
    rd_short("R7", 6, 1'b0);
    rd_full("R7", 8'h08);

    wr_frame("R8", 8'hC6, 8'd6, 8'd0, 8'd10, 8'h66, 8'h67, 0, 0, 2);
    rd_short("R8", 6, 1'b0);
    wr_frame("R8", 8'hC4, 8'd5, 8'd0, 8'd10, 8'h66, 0, 0, 0, 1);
    rd_short("R8", 6, 1'b0);
    wr_frame("R8", 8'h46, 8'd5, 8'd0, 8'd10, 8'h66, 0, 0, 0, 1);
    rd_full("R8", 8'h08);

    wr_frame("R9", 8'hC6, 8'd5, 8'd0, 8'd20, 8'h77, 8'h99, 0, 0, 2);
    rd_short("R9", 6, 1'b0);
    wr_frame("R9", 8'hC6, 8'd5, 8'd0, 8'd21, 0, 0, 0, 0, 0);
    rd_short("R9", 6, 1'b0);

    bus_start();
    put_byte({7'h5A, 1'b0}, ack);
    chk(!ack, "R2", ack, 0);
    put_byte(8'hC6, ack); put_byte(8'h05, ack);
    bus_stop();
    rd_short("R2", 6, 1'b0);

    rd_full("R6", 8'h14);
    rd_short("R6", 7, 1'b1);
    wq(8);
    chk(sda_oe == 1'b0, "R10", sda_oe, 0);

    chk(viol == 0, "R10", viol, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule